// File: doc/BRIEF.md
# Clock Source Selector Bank

This block holds six independent consumer-clock selectors behind one 32-bit source-control register. Each selector picks one of seven candidate clocks (one auxiliary clock and six generator outputs) or an off state. It then divides the chosen clock by a small factor taken from a fixed four-entry table and drives one internal consumer clock. Software writes the whole register in one access and can read it back at any time.

The candidate clocks are sampled in the system clock domain. Each one passes through a synchronizer and a rising-edge detector, and the dividers count the detected edges. Every consumer output is therefore a registered signal in the system domain. Two variants exist, chosen by a parameter, and they differ only in what divider code 2 means. When a new setting is written, it waits in the register until the running output period has finished, so a change never shortens a pulse.

Top module: `csel_bank`

## Requirements
- R1: Selector i owns register bits [5i+4:5i]. Bits [1:0] of that field are the divider code and bits [4:2] are the source code. A write stores bits [29:0], and the read port returns them from the next cycle on. Bits [31:30] always read as zero.
- R2: After reset the register reads zero and every consumer output is low.
- R3: A selector whose source code is 0 holds its output low.
- R4: Source code 1 selects the auxiliary clock (candidate input bit 0). Source codes 2 to 7 select generator outputs 0 to 5 (candidate input bits 1 to 6). An output rises only on a rising edge of the selected candidate.
- R5: In the default variant, divider codes 0, 1, 2 and 3 divide by 1, 4, 1 and 2.
- R6: In the alternate variant, divider code 2 divides by 3. The output is high for one candidate period and low for the next two.
- R7: Division by 2 or by 4 gives an output high for half of its period, which is 2 or 4 candidate periods long.
- R8: Division by 1 reproduces the selected candidate's high and low times.
- R9: A new source or divider code takes effect only after the output is low and its current period has finished. The pulse in progress keeps its old width, and no output pulse is ever shorter than a phase of a candidate clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples candidates and clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Write strobe for the source-control register |
| cfg_wdata | input | 32 | Write data for the source-control register |
| cfg_rdata | output | 32 | Current contents of the source-control register |
| cand_clk | input | 7 | Candidate clocks: bit 0 is the auxiliary clock, bits 1 to 6 are generators 0 to 5 |
| cons_clk | output | 6 | Consumer clock outputs, one per selector |

## Verification
The assertions assume two things about the inputs. Every high and low phase of a candidate clock must last at least two system cycles, so that the synchronizer and edge detector see each edge. A selected candidate must also keep toggling, so that a pending change eventually reaches an idle point. The bench meets both conditions. It builds each candidate from the system clock with a fixed half-period of two to eight cycles that differs from one candidate to the next. It never stops a candidate while a selector depends on it.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int SRC_W   = 3;
  localparam int DIV_W   = 2;
  localparam int FIELD_W = SRC_W + DIV_W;

  // field layout: source code in the upper bits, divider code in the lower bits
  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } sel_cfg_t;

  // divider code to division ratio; the alternate variant changes code 2 only
  function automatic logic [2:0] div_ratio(input logic [DIV_W-1:0] code,
                                           input logic alt);
    logic [2:0] r;
    case (code)
      2'd0:    r = 3'd1;
      2'd1:    r = 3'd4;
      2'd2:    r = alt ? 3'd3 : 3'd1;
      default: r = 3'd2;
    endcase
    return r;
  endfunction

  // number of candidate periods the output stays high within one period
  function automatic logic [1:0] high_slots(input logic [2:0] ratio);
    return (ratio == 3'd3) ? 2'd1 : ratio[2:1];
  endfunction

endpackage

// File: rtl/csel_edge.sv
module csel_edge #(
  parameter int LANES  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] lvl_o,
  output logic [LANES-1:0] rise_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] sh_q, sh_n;
    logic              prev_q;

    always_comb sh_n = {sh_q[STAGES-2:0], din[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        prev_q <= 1'b0;
      end else begin
        sh_q   <= sh_n;
        prev_q <= sh_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = sh_q[STAGES-1];
    assign rise_o[g] = sh_q[STAGES-1] & ~prev_q;

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
#(
  parameter int NUM_CAND = 7,
  parameter bit ALT_DIV3 = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sel_cfg_t            pend_i,
  input  logic [NUM_CAND-1:0] lvl_i,
  input  logic [NUM_CAND-1:0] rise_i,
  output logic                clk_o
);

  sel_cfg_t   act_q, act_n;
  logic [1:0] cnt_q, cnt_n;
  logic       out_q, out_n;
  logic       sel_lvl, sel_rise;
  logic [2:0] ratio;
  logic [1:0] hslots;
  logic       idle, swap, run_en;

  // candidate select: code k+1 picks candidate k, code 0 picks nothing
  always_comb begin
    sel_lvl  = 1'b0;
    sel_rise = 1'b0;
    for (int k = 0; k < NUM_CAND; k++) begin
      if (act_q.src == SRC_W'(k + 1)) begin
        sel_lvl  = lvl_i[k];
        sel_rise = rise_i[k];
      end
    end
  end

  always_comb begin
    ratio  = div_ratio(act_q.div, ALT_DIV3);
    hslots = high_slots(ratio);
    idle   = (cnt_q == 2'd0) && !out_q;
    swap   = idle && (pend_i != act_q);
    run_en = (act_q.src != '0) && ((ratio == 3'd1) || sel_rise);
  end

  // next state
  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    out_n = out_q;
    if (swap) begin
      act_n = pend_i;
      cnt_n = 2'd0;
      out_n = 1'b0;
    end else if (run_en) begin
      if (ratio == 3'd1) begin
        out_n = sel_rise | (out_q & sel_lvl);
        cnt_n = 2'd0;
      end else begin
        out_n = (cnt_q < hslots);
        cnt_n = ({1'b0, cnt_q} == ratio - 3'd1) ? 2'd0 : cnt_q + 2'd1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= 2'd0;
      out_q <= 1'b0;
    end else begin
      if (swap) act_q <= act_n;
      if (swap || run_en) begin
        cnt_q <= cnt_n;
        out_q <= out_n;
      end
    end
  end

  assign clk_o = out_q;

  // R3
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.src == '0) |-> !out_q);

  // R9
  swap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> (!$past(out_q) && ($past(cnt_q) == 2'd0)));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q.src != '0) |-> ({1'b0, cnt_q} < ratio));

  // R4
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(sel_rise));

endmodule

// File: rtl/csel_bank.sv
module csel_bank
  import csel_pkg::*;
#(
  parameter int NUM_SEL     = 6,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit ALT_DIV3    = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic [NUM_SEL:0]   cand_clk,
  output logic [NUM_SEL-1:0] cons_clk
);

  localparam int NUM_CAND = NUM_SEL + 1;
  localparam int CFG_W    = NUM_SEL * FIELD_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_in_n = rsync_q[1];

  // source-control register
  logic [CFG_W-1:0] cfg_q, cfg_n;

  always_comb cfg_n = cfg_we ? cfg_wdata[CFG_W-1:0] : cfg_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)   cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_n;
  end

  assign cfg_rdata = REG_W'(cfg_q);

  if (REG_W > CFG_W) begin : g_spare
    logic unused_wr_hi;
    assign unused_wr_hi = ^cfg_wdata[REG_W-1:CFG_W];
  end

  // candidate synchronizers and edge detectors
  logic [NUM_CAND-1:0] lvl, rise;

  csel_edge #(.LANES(NUM_CAND), .STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .din    (cand_clk),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  // one selector per consumer
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    sel_cfg_t pend;
    assign pend = sel_cfg_t'(cfg_q[g*FIELD_W +: FIELD_W]);

    csel_unit #(.NUM_CAND(NUM_CAND), .ALT_DIV3(ALT_DIV3)) u_unit (
      .clk    (clk),
      .rst_n  (rst_in_n),
      .pend_i (pend),
      .lvl_i  (lvl),
      .rise_i (rise),
      .clk_o  (cons_clk[g])
    );
  end

  // R1
  rdback_chk: assert property (@(posedge clk) disable iff (!rst_in_n)
    cfg_we |=> (cfg_rdata[CFG_W-1:0] == $past(cfg_wdata[CFG_W-1:0])));

endmodule

// File: tb/sim_csel_bank.sv
module sim_csel_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] rdata0, rdata1;
  logic [6:0]  cand;
  logic [5:0]  cons0, cons1;

  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  int   runts = 0;
  bit   done = 1'b0;
  logic [31:0] shadow = '0;
  int   ccnt [7];
  int   runl [2][6];
  logic prv  [2][6];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csel_bank #(.ALT_DIV3(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata0), .cand_clk(cand), .cons_clk(cons0));

  csel_bank #(.ALT_DIV3(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rdata1), .cand_clk(cand), .cons_clk(cons1));

  // vector: {selector[2:0], source code[2:0], divider code[1:0]}
  localparam int NV = 8;
  localparam logic [7:0] VEC [NV] = '{
    {3'd0, 3'd1, 2'd0}, {3'd1, 3'd2, 2'd1}, {3'd2, 3'd3, 2'd3},
    {3'd3, 3'd7, 2'd2}, {3'd4, 3'd4, 2'd2}, {3'd5, 3'd5, 2'd1},
    {3'd0, 3'd6, 2'd3}, {3'd5, 3'd2, 2'd0}
  };

  // candidate j: half-period j+2 system cycles
  initial begin
    cand = '0;
    forever begin
      @(negedge clk);
      for (int j = 0; j < 7; j++) begin
        if (ccnt[j] == j + 1) begin
          ccnt[j] = 0;
          cand[j] = ~cand[j];
        end else begin
          ccnt[j] = ccnt[j] + 1;
        end
      end
    end
  end

  function automatic logic get_out(int u, int s);
    return (u == 0) ? cons0[s] : cons1[s];
  endfunction

  // pulse-width monitor for R9: no run shorter than two cycles
  initial begin
    for (int u = 0; u < 2; u++)
      for (int s = 0; s < 6; s++) begin
        runl[u][s] = 100;
        prv[u][s]  = 1'b0;
      end
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        for (int u = 0; u < 2; u++)
          for (int s = 0; s < 6; s++) begin
            if (get_out(u, s) !== prv[u][s]) begin
              if (runl[u][s] < 2) runts++;
              runl[u][s] = 1;
              prv[u][s]  = get_out(u, s);
            end else begin
              runl[u][s] = runl[u][s] + 1;
            end
          end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
    shadow    = d;
  endtask

  task automatic set_field(input int s, input int src, input int dv);
    logic [31:0] d;
    logic [2:0]  sc;
    logic [1:0]  dc;
    sc = src[2:0];
    dc = dv[1:0];
    d  = shadow;
    d[s*5 +: 5] = {sc, dc};
    wr(d);
  endtask

  task automatic wait_lvl(input int u, input int s, input logic v, inout int to);
    while (get_out(u, s) !== v && to > 0) begin
      @(negedge clk);
      to--;
    end
  endtask

  task automatic measure(input int u, input int s, output int per, output int hi);
    int to, t1, tf, t2;
    to = 600;
    @(negedge clk);
    wait_lvl(u, s, 1'b0, to);
    wait_lvl(u, s, 1'b1, to);
    t1 = cyc;
    wait_lvl(u, s, 1'b0, to);
    tf = cyc;
    wait_lvl(u, s, 1'b1, to);
    t2 = cyc;
    if (to == 0) begin
      per = -1;
      hi  = -1;
    end else begin
      per = t2 - t1;
      hi  = tf - t1;
    end
  endtask

  // expected ratio from the divider table (R5, R6)
  function automatic int exp_ratio(input int dv, input int alt);
    case (dv)
      0: return 1;
      1: return 4;
      2: return alt ? 3 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic int exp_high(input int n, input int p);
    if (n == 1) return p / 2;
    if (n == 3) return p;
    return (n / 2) * p;
  endfunction

  // watchdog
  initial begin
    while (cyc < 150000 && !done) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int per, hi, n, p, cnt;
    string tag;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R2 reset state
    chk("R2 rdata after reset", int'(rdata0), 0);
    chk("R2 outputs after reset", int'({cons1, cons0}), 0);

    // R1 readback and field position
    wr(32'hFFFF_FFFF);
    chk("R1 upper bits read zero", int'(rdata0), int'(32'h3FFF_FFFF));
    wr(32'hC000_0021);
    chk("R1 readback", int'(rdata1), int'(32'h0000_0021));
    wr(32'h0);
    set_field(3, 5, 2);
    chk("R1 selector 3 field at bits 19:15", int'(rdata0), int'(32'h000B_0000));
    wr(32'h0);
    repeat (150) @(negedge clk);

    // table walk: R4 source select, R5..R8 division
    for (int v = 0; v < NV; v++) begin
      set_field(int'(VEC[v][7:5]), int'(VEC[v][4:2]), int'(VEC[v][1:0]));
      repeat (150) @(negedge clk);
      p = 2 * (int'(VEC[v][4:2]) + 1);
      for (int u = 0; u < 2; u++) begin
        n = exp_ratio(int'(VEC[v][1:0]), u);
        tag = (n == 1) ? "R8" : (n == 3) ? "R6" : "R7";
        measure(u, int'(VEC[v][7:5]), per, hi);
        chk($sformatf("R4 R5 %s vec%0d u%0d period", tag, v, u), per, n * p);
        chk($sformatf("R4 R5 %s vec%0d u%0d high", tag, v, u), hi, exp_high(n, p));
      end
    end

    // R3 disabled selector stays low
    set_field(2, 0, 1);
    repeat (100) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (cons0[2] || cons1[2]) cnt++;
    end
    chk("R3 disabled output high cycles", cnt, 0);

    // R9 change while a pulse is high: pulse keeps its old width
    set_field(1, 1, 1);
    repeat (150) @(negedge clk);
    begin
      int to;
      logic [31:0] d;
      to = 600;
      wait_lvl(0, 1, 1'b0, to);
      wait_lvl(0, 1, 1'b1, to);
      d = shadow;
      d[9:5] = {3'd1, 2'd0};
      cfg_we    = 1'b1;
      cfg_wdata = d;
      shadow    = d;
      cnt = 1;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        cfg_we = 1'b0;
        if (cons0[1]) cnt++;
        else break;
      end
    end
    chk("R9 pulse in progress keeps width", cnt, 8);
    repeat (100) @(negedge clk);
    measure(0, 1, per, hi);
    chk("R9 new setting applied after period", per, 4);

    // R9 glitch stress: rapid reconfiguration at scattered times
    for (int i = 0; i < 24; i++) begin
      set_field(0, (i % 7) + 1, i % 4);
      repeat (((i * 7) % 13) + 1) @(negedge clk);
    end
    repeat (200) @(negedge clk);
    chk("R9 runt pulses observed", runts, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule